// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This unit collects the event pulses of a storage-card host controller into a sticky status word, masks them with a software-held enable word, and raises one level interrupt while any enabled event is pending. Sixteen event sources feed it:

- the card's SDIO interrupt;
- response done and end of chain;
- two timeouts (descriptor and response);
- four error kinds: response, descriptor, transmit, and a receive error for each of the eight data lanes.

Software reads both words over a 32-bit register port. It clears events by writing ones to the status word.

The status word also carries two live busy flags from the command and descriptor engines. The unit gives two summary outputs, one for any pending timeout and one for any pending error. Interrupt handlers use them to pick a completion code without decoding the whole word.

The register port completes in one cycle. Writes take effect on the clock edge on which they are presented. Read data is combinational from the current address and register contents.

Top module: `irq_status_unit`

## Requirements
- R1: A synchronous reset clears every status event bit and every enable bit. The reset has priority over event pulses and writes presented in the same cycle.
- R2: An event pulse sets its status bit (offset 0x48) at the next clock edge. The bit positions are:
  - SDIO interrupt at 15;
  - response done at 14;
  - end of chain at 13;
  - descriptor timeout at 12;
  - response timeout at 11;
  - response error at 10;
  - descriptor error at 9;
  - transmit error at 8;
  - receive error of lane n at bit n, for n = 0 to 7.
- R3: A write to offset 0x48 clears each event bit whose data bit is 1 and leaves each bit whose data bit is 0 unchanged. With no write, a set event bit stays set.
- R4: When an event pulse and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R5: The enable word at offset 0x4C stores data bits 16:0 on a write and reads them back; bits 31:17 read as 0. Bit 16 is a secure-configuration flag.
- R6: `irq` is high exactly when status bits 15:0 ANDed with enable bits 15:0 are nonzero. Enable bit 16 has no effect on `irq`.
- R7: Status bits 31 and 30 show `core_busy` and `desc_busy` live, in the same cycle. Writes to them are ignored. Status bits 29:16 read as 0.
- R8: `timeout_sum` is the OR of status bits 12 and 11. `error_sum` is the OR of status bits 10:0.
- R9: Writing the value 0x00008000 to the status word clears only the SDIO interrupt bit and leaves every other pending event set.
- R10: A write to any other offset changes no register. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_sdio | input | 1 | SDIO card interrupt pulse |
| ev_resp_done | input | 1 | Response done pulse |
| ev_chain_end | input | 1 | End of descriptor chain pulse |
| ev_desc_tmo | input | 1 | Descriptor timeout pulse |
| ev_resp_tmo | input | 1 | Response timeout pulse |
| ev_resp_err | input | 1 | Response error pulse |
| ev_desc_err | input | 1 | Descriptor error pulse |
| ev_tx_err | input | 1 | Transmit data error pulse |
| ev_rx_err | input | 8 | Receive data error pulses, one per lane |
| core_busy | input | 1 | Live command engine busy flag |
| desc_busy | input | 1 | Live descriptor engine busy flag |
| bus_addr | input | 8 | Register byte offset for read and write |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Level interrupt |
| timeout_sum | output | 1 | Any timeout pending |
| error_sum | output | 1 | Any error pending |

## Verification
Event pulses and register writes show up one clock edge later in the stored words. They also show up one edge later in `irq`, the two summaries and the read data, because those outputs are combinational from the stored words. The busy flags and the read address reach `bus_rdata` in the same cycle.

The bench drives all inputs 1 ns after the falling edge. It updates its own model at the rising edge, from the same inputs. It compares all four outputs at the following falling edge. Each comparison therefore sees exactly one edge's worth of change, and the same-cycle busy path is compared in the cycle it is driven.

// File: rtl/isu_pkg.sv
package isu_pkg;

  // Lane count of the receive error field; the event layout depends on it.
  localparam int RX_LANES = 8;
  localparam int EV_W     = RX_LANES + 8;
  localparam int EN_W     = EV_W + 1;

  // Event bit positions inside the status word.
  localparam int B_SDIO      = RX_LANES + 7;
  localparam int B_RESP_DONE = RX_LANES + 6;
  localparam int B_CHAIN_END = RX_LANES + 5;
  localparam int B_DESC_TMO  = RX_LANES + 4;
  localparam int B_RESP_TMO  = RX_LANES + 3;
  localparam int B_RESP_ERR  = RX_LANES + 2;
  localparam int B_DESC_ERR  = RX_LANES + 1;
  localparam int B_TX_ERR    = RX_LANES;
  localparam int B_SECURE    = EV_W;

  typedef logic [EV_W-1:0] ev_vec_t;
  typedef logic [EN_W-1:0] en_vec_t;

  // One bit of write-one-to-clear storage: a set pulse outranks a clear.
  function automatic logic w1c_bit(input logic cur, input logic set,
                                   input logic clr);
    return set | (cur & ~clr);
  endfunction

  function automatic ev_vec_t timeout_mask();
    ev_vec_t m;
    m = '0;
    m[B_DESC_TMO] = 1'b1;
    m[B_RESP_TMO] = 1'b1;
    return m;
  endfunction

  function automatic ev_vec_t error_mask();
    ev_vec_t m;
    m = '0;
    m[B_RESP_ERR] = 1'b1;
    m[B_DESC_ERR] = 1'b1;
    m[B_TX_ERR]   = 1'b1;
    for (int i = 0; i < RX_LANES; i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic logic any_pending(input ev_vec_t st, input ev_vec_t mask);
    return |(st & mask);
  endfunction

endpackage

// File: rtl/isu_event_bank.sv
module isu_event_bank
  import isu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  ev_vec_t set_vec,
  input  logic    clr_en,
  input  ev_vec_t clr_vec,
  output ev_vec_t status_q
);

  genvar g;
  generate
    for (g = 0; g < EV_W; g++) begin : g_bit
      logic clr_hit;
      assign clr_hit = clr_en & clr_vec[g];

      always_ff @(posedge clk) begin
        if (rst) status_q[g] <= 1'b0;
        else     status_q[g] <= w1c_bit(status_q[g], set_vec[g], clr_hit);
      end
    end
  endgenerate

endmodule

// File: rtl/isu_enable_reg.sv
module isu_enable_reg
  import isu_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    wr_en,
  input  en_vec_t wr_val,
  output en_vec_t en_q
);

  always_ff @(posedge clk) begin
    if (rst)        en_q <= '0;
    else if (wr_en) en_q <= wr_val;
  end

endmodule

// File: rtl/isu_reduce.sv
module isu_reduce
  import isu_pkg::*;
(
  input  ev_vec_t status_q,
  input  en_vec_t en_q,
  output logic    irq,
  output logic    timeout_sum,
  output logic    error_sum
);

  ev_vec_t ev_en;
  logic    secure_unused;

  assign ev_en         = en_q[EV_W-1:0];
  assign secure_unused = en_q[B_SECURE];

  assign irq         = any_pending(status_q, ev_en);
  assign timeout_sum = any_pending(status_q, timeout_mask());
  assign error_sum   = any_pending(status_q, error_mask());

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import isu_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_OFS = 8'h48,
  parameter logic [ADDR_W-1:0] ENABLE_OFS = 8'h4C,
  parameter int CORE_BUSY_BIT = 31,
  parameter int DESC_BUSY_BIT = 30
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ev_sdio,
  input  logic                ev_resp_done,
  input  logic                ev_chain_end,
  input  logic                ev_desc_tmo,
  input  logic                ev_resp_tmo,
  input  logic                ev_resp_err,
  input  logic                ev_desc_err,
  input  logic                ev_tx_err,
  input  logic [RX_LANES-1:0] ev_rx_err,
  input  logic                core_busy,
  input  logic                desc_busy,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq,
  output logic                timeout_sum,
  output logic                error_sum
);

  localparam int HI_UNUSED_LO = EN_W;

  // Named internal events, also observed by the bound checker.
  ev_vec_t ev_vec;
  ev_vec_t status_q;
  en_vec_t en_q;
  logic    rd_is_stat;
  logic    rd_is_en;
  logic    wr_stat;
  logic    wr_en_reg;
  logic    unused_wdata_hi;

  assign ev_vec = {ev_sdio, ev_resp_done, ev_chain_end, ev_desc_tmo,
                   ev_resp_tmo, ev_resp_err, ev_desc_err, ev_tx_err,
                   ev_rx_err};

  assign rd_is_stat = (bus_addr == STATUS_OFS);
  assign rd_is_en   = (bus_addr == ENABLE_OFS);
  assign wr_stat    = bus_wr & rd_is_stat;
  assign wr_en_reg  = bus_wr & rd_is_en;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:HI_UNUSED_LO];

  isu_event_bank u_bank (
    .clk      (clk),
    .rst      (rst),
    .set_vec  (ev_vec),
    .clr_en   (wr_stat),
    .clr_vec  (bus_wdata[EV_W-1:0]),
    .status_q (status_q)
  );

  isu_enable_reg u_enable (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_en_reg),
    .wr_val (bus_wdata[EN_W-1:0]),
    .en_q   (en_q)
  );

  isu_reduce u_reduce (
    .status_q    (status_q),
    .en_q        (en_q),
    .irq         (irq),
    .timeout_sum (timeout_sum),
    .error_sum   (error_sum)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_is_stat) begin
      bus_rdata[EV_W-1:0]    = status_q;
      bus_rdata[CORE_BUSY_BIT] = core_busy;
      bus_rdata[DESC_BUSY_BIT] = desc_busy;
    end else if (rd_is_en) begin
      bus_rdata[EN_W-1:0] = en_q;
    end
  end

endmodule

// File: rtl/isu_checker.sv
module isu_checker
  import isu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input ev_vec_t           ev_vec,
  input ev_vec_t           status_q,
  input en_vec_t           en_q,
  input logic              wr_stat,
  input logic              wr_en_reg,
  input logic              rd_is_stat,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              core_busy,
  input logic              desc_busy,
  input logic              irq,
  input logic              timeout_sum
);

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((status_q & ~$past(status_q) & ~$past(ev_vec)) == '0)); // R2

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((status_q & $past(ev_vec)) == $past(ev_vec))); // R4

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_stat) |=> ((status_q & $past(bus_wdata[EV_W-1:0] & ~ev_vec)) == '0)); // R3

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!rst && !wr_stat) |=> ((status_q & $past(status_q)) == $past(status_q))); // R3

  AST_EN_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_en_reg) |=> (en_q == $past(bus_wdata[EN_W-1:0]))); // R5

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (rst)
    irq == ((status_q & en_q[EV_W-1:0]) != '0)); // R6

  AST_BUSY_LIVE: assert property (@(posedge clk) disable iff (rst)
    rd_is_stat |-> (bus_rdata[31:30] == {core_busy, desc_busy})); // R7

  AST_TIMEOUT_SUM: assert property (@(posedge clk) disable iff (rst)
    timeout_sum == (status_q[B_DESC_TMO] | status_q[B_RESP_TMO])); // R8

endmodule

bind irq_status_unit isu_checker #(.DATA_W(DATA_W)) u_isu_chk (
  .clk         (clk),
  .rst         (rst),
  .ev_vec      (ev_vec),
  .status_q    (status_q),
  .en_q        (en_q),
  .wr_stat     (wr_stat),
  .wr_en_reg   (wr_en_reg),
  .rd_is_stat  (rd_is_stat),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .core_busy   (core_busy),
  .desc_busy   (desc_busy),
  .irq         (irq),
  .timeout_sum (timeout_sum)
);

// File: tb/test_irq_status_unit.sv
`timescale 1ns/1ps
module test_irq_status_unit;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] ev = '0;
  logic        core_busy = 1'b0;
  logic        desc_busy = 1'b0;
  logic [7:0]  bus_addr = 8'h48;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, timeout_sum, error_sum;

  always #2.5 clk = ~clk;

  irq_status_unit i_irq_status_unit (
    .clk(clk), .rst(rst),
    .ev_sdio(ev[15]), .ev_resp_done(ev[14]), .ev_chain_end(ev[13]),
    .ev_desc_tmo(ev[12]), .ev_resp_tmo(ev[11]), .ev_resp_err(ev[10]),
    .ev_desc_err(ev[9]), .ev_tx_err(ev[8]), .ev_rx_err(ev[7:0]),
    .core_busy(core_busy), .desc_busy(desc_busy),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .timeout_sum(timeout_sum),
    .error_sum(error_sum)
  );

  // Reference model state
  bit    m_st[16];
  bit    m_en[17];
  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    chk_on = 0;
  string tag = "R1";

  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      for (int i = 0; i < 16; i++) m_st[i] = 0;
      for (int i = 0; i < 17; i++) m_en[i] = 0;
      chk_on = 1;
    end else begin
      for (int i = 0; i < 16; i++) begin
        if (bus_wr && bus_addr == 8'h48 && bus_wdata[i]) m_st[i] = 0;
        if (ev[i]) m_st[i] = 1;
      end
      if (bus_wr && bus_addr == 8'h4C)
        for (int i = 0; i < 17; i++) m_en[i] = bus_wdata[i];
    end
  end

  task automatic check(input string what, input logic [31:0] got,
                       input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s got %h expected %h", tag, what, got, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      logic [31:0] e_rd;
      int e_irq, e_t, e_e;
      e_rd = 0;
      if (bus_addr == 8'h48) begin
        for (int i = 0; i < 16; i++) e_rd[i] = m_st[i];
        e_rd[31] = core_busy;
        e_rd[30] = desc_busy;
      end else if (bus_addr == 8'h4C) begin
        for (int i = 0; i < 17; i++) e_rd[i] = m_en[i];
      end
      e_irq = 0;
      e_e = 0;
      for (int i = 0; i < 16; i++) if (m_st[i] && m_en[i]) e_irq = 1;
      for (int i = 0; i < 11; i++) if (m_st[i]) e_e = 1;
      e_t = (m_st[12] || m_st[11]) ? 1 : 0;
      check("bus_rdata", bus_rdata, e_rd);
      check("irq", {31'b0, irq}, e_irq);
      check("timeout_sum", {31'b0, timeout_sum}, e_t);
      check("error_sum", {31'b0, error_sum}, e_e);
    end
  end

  // One cycle of stimulus, applied just after the falling edge.
  task automatic cyc(input logic [15:0] e, input logic w,
                     input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    #1;
    ev = e;
    bus_wr = w;
    bus_addr = a;
    bus_wdata = d;
  endtask

  task automatic idle(input logic [7:0] a);
    cyc(16'h0, 1'b0, a, 32'h0);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    #400000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset clears, and outranks pulses and writes
    tag = "R1";
    cyc(16'hFFFF, 1'b1, 8'h4C, 32'hFFFF_FFFF);
    cyc(16'hFFFF, 1'b1, 8'h48, 32'h0);
    idle(8'h4C);
    idle(8'h48);
    #1 rst = 1'b0;
    idle(8'h4C);
    idle(8'h48);

    // R2: each event sets its own bit
    tag = "R2";
    for (int i = 0; i < 16; i++) begin
      cyc(16'(1 << i), 1'b0, 8'h48, 32'h0);
      idle(8'h48);
      cyc(16'h0, 1'b1, 8'h48, 32'h0000_FFFF);
      idle(8'h48);
    end

    // R8: timeout and error summaries
    tag = "R8";
    cyc(16'h1000, 1'b0, 8'h48, 32'h0);
    idle(8'h48);
    cyc(16'h0800, 1'b1, 8'h48, 32'h1000);
    idle(8'h48);
    cyc(16'h0080, 1'b1, 8'h48, 32'h0800);
    idle(8'h48);
    cyc(16'h0400, 1'b1, 8'h48, 32'h0080);
    cyc(16'h0, 1'b1, 8'h48, 32'h0400);
    cyc(16'hE000, 1'b0, 8'h48, 32'h0);
    idle(8'h48);

    // R3: write-one-to-clear on a subset, zero leaves
    tag = "R3";
    cyc(16'hFFFF, 1'b0, 8'h48, 32'h0);
    cyc(16'h0, 1'b1, 8'h48, 32'h0000_00A5);
    cyc(16'h0, 1'b1, 8'h48, 32'h0);
    idle(8'h48);
    idle(8'h48);
    cyc(16'h0, 1'b1, 8'h48, 32'h0000_FFFF);

    // R4: set and clear in the same cycle
    tag = "R4";
    cyc(16'h0020, 1'b1, 8'h48, 32'h0000_0020);
    idle(8'h48);
    cyc(16'h8000, 1'b1, 8'h48, 32'h0000_FFFF);
    idle(8'h48);

    // R9: acknowledge only the SDIO interrupt
    tag = "R9";
    cyc(16'hFFFF, 1'b0, 8'h48, 32'h0);
    cyc(16'h0, 1'b1, 8'h48, 32'h0000_8000);
    idle(8'h48);

    // R5: enable storage and readback
    tag = "R5";
    cyc(16'h0, 1'b1, 8'h4C, 32'hFFFF_FFFF);
    idle(8'h4C);
    cyc(16'h0, 1'b1, 8'h4C, 32'h0001_2345);
    idle(8'h4C);

    // R6: interrupt masking, secure bit alone raises nothing
    tag = "R6";
    cyc(16'h0, 1'b1, 8'h48, 32'h0000_FFFF);
    cyc(16'h0, 1'b1, 8'h4C, 32'h0001_0000);
    cyc(16'hFFFF, 1'b0, 8'h4C, 32'h0);
    idle(8'h48);
    cyc(16'h0, 1'b1, 8'h4C, 32'h0000_2000);
    idle(8'h48);
    cyc(16'h0, 1'b1, 8'h48, 32'h0000_2000);
    idle(8'h48);
    cyc(16'h0, 1'b1, 8'h48, 32'h0000_FFFF);
    idle(8'h48);

    // R7: live busy flags, writes ignored
    tag = "R7";
    core_busy = 1'b1;
    idle(8'h48);
    desc_busy = 1'b1;
    cyc(16'h0, 1'b1, 8'h48, 32'hFFFF_0000);
    core_busy = 1'b0;
    idle(8'h48);
    desc_busy = 1'b0;
    idle(8'h48);

    // R10: other offsets neither write nor read
    tag = "R10";
    cyc(16'h00F0, 1'b0, 8'h48, 32'h0);
    cyc(16'h0, 1'b1, 8'h50, 32'hFFFF_FFFF);
    idle(8'h50);
    idle(8'h48);
    idle(8'h4C);

    // Mixed traffic: R2 R3 R5 R6 R7 R8 together
    tag = "R2 R3 R6 mixed";
    for (int k = 0; k < 600; k++) begin
      logic [7:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel == 0) ? 8'h4C : (sel == 1) ? 8'h54 : 8'h48;
      core_busy = 1'($urandom);
      desc_busy = 1'($urandom);
      cyc(16'($urandom) & 16'($urandom), 1'($urandom_range(0, 2) == 0),
          a, $urandom);
    end
    idle(8'h48);
    idle(8'h48);
    finish_run();
  end

endmodule